// File: doc/BRIEF.md
# Compare-Clear Timer with Toggle Output

This block is a 16-bit up-counter that restarts from zero when it reaches a programmable compare value. It is used to make a square wave of programmable frequency, or a periodic event. A free-running 10-bit clock divider produces a single-cycle advance enable. A select input picks whether the counter advances on every clock, every 8th, 64th, 256th or 1024th clock, or not at all.

Each time the counter leaves the compare value, the block raises a sticky match flag. It can also invert an internal waveform bit, which reaches the output pin only when the pin is enabled as an output. Rolling over from 0xFFFF to 0x0000 raises a sticky overflow flag.

The compare value is written straight into the live register, with no shadow copy. Writing a value that is already behind the count therefore makes the counter run all the way round before the next match. With a compare value of 0 and divide-by-1, the pin runs at half the clock rate. In general the pin frequency is f_clk / (2·N·(1+compare)).

Top module: `ctc_timer`

## Requirements
- R1: A free-running 10-bit divider starts at 0 after reset and increments on every clock. The counter advances by one on a clock where the divider's low k bits are all ones. k is 0, 3, 6, 8 or 10 for `clk_sel_i` = 1, 2, 3, 4 or 5. Select values 0, 6 and 7 halt the counter.
- R2: On an advance while the count equals the compare register, the count becomes 0 and a match event occurs.
- R3: A compare write (`cmp_we_i`=1) replaces the compare register at the next clock edge, with no buffering. If the new value is below the count, no match occurs until the count has passed 0xFFFF, wrapped to 0 and climbed to the new value.
- R4: With `out_mode_i` = 1, the internal waveform bit inverts on every match event. With any other mode it holds its value.
- R5: `wave_o` equals the waveform bit when `pin_oe_i`=1 and `out_mode_i`=1. Otherwise it is 0.
- R6: `match_flag_o` is set by a match event and stays set until a clock with `match_clr_i`=1. When a set and a clear coincide, the set wins.
- R7: `ovf_flag_o` is set by an advance from 0xFFFF to 0x0000, including when the compare value is 0xFFFF. It stays set until a clock with `ovf_clr_i`=1. When a set and a clear coincide, the set wins.
- R8: While `rst_ni` is low, the count, the divider, the compare register, the waveform bit and both flags are 0.
- R9: With a compare value of 0 and `clk_sel_i`=1, `wave_o` inverts on every clock, which is half the clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 3 | Advance rate select (0 halts) |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | 16 | Compare register write data |
| out_mode_i | input | 2 | Output mode (1 = toggle on match) |
| pin_oe_i | input | 1 | Pin output enable |
| match_clr_i | input | 1 | Clear match flag |
| ovf_clr_i | input | 1 | Clear overflow flag |
| wave_o | output | 1 | Waveform pin |
| match_flag_o | output | 1 | Sticky compare-match flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The bench lowers the compare value below a running count. A design that buffered the write, or that compared with greater-or-equal, would match early instead of wrapping through 0xFFFF. It pulses both clears on every clock while matches fire each cycle, so a design that let a clear win would show a dropped flag. It walks every divide ratio and the halt selects; an off-by-one in the divider mask would shift every advance. It also runs a compare value of 0 at full rate, where a design that restarted at 1, or that took an extra cycle to restart, would halve the pin frequency.

// File: rtl/ctc_pkg.sv
package ctc_pkg;
  localparam int CNT_W = 16;
  localparam int DIV_W = 10;

  typedef enum logic [2:0] {
    SEL_OFF   = 3'd0,
    SEL_D1    = 3'd1,
    SEL_D8    = 3'd2,
    SEL_D64   = 3'd3,
    SEL_D256  = 3'd4,
    SEL_D1024 = 3'd5
  } rate_sel_e;

  localparam logic [1:0] MODE_TOGGLE = 2'd1;

  // number of divider low bits that must be all ones for an advance
  function automatic int rate_shift(logic [2:0] sel);
    case (sel)
      SEL_D8:    return 3;
      SEL_D64:   return 6;
      SEL_D256:  return 8;
      SEL_D1024: return 10;
      default:   return 0;
    endcase
  endfunction
endpackage

// File: rtl/ctc_prescaler.sv
module ctc_prescaler
  import ctc_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [DW-1:0] div_q;
  logic [DW-1:0] mask;
  logic          run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  assign run    = (sel_i >= 3'(SEL_D1)) && (sel_i <= 3'(SEL_D1024));
  assign mask   = ~({DW{1'b1}} << rate_shift(sel_i));
  assign tick_o = run && ((div_q & mask) == mask);

  // R1: a full /1024 advance only on the all-ones divider value
  p_div_1024_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == 3'(SEL_D1024)) |-> (div_q == {DW{1'b1}}));
endmodule

// File: rtl/ctc_counter.sv
module ctc_counter
  import ctc_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cmp_we_i,
  input  logic [CW-1:0] cmp_wdata_i,
  input  logic          match_clr_i,
  input  logic          ovf_clr_i,
  output logic          match_o,
  output logic          match_flag_o,
  output logic          ovf_flag_o
);
  logic [CW-1:0] cnt_q, cmp_q;
  logic          wrap;

  assign match_o = tick_i && (cnt_q == cmp_q);
  assign wrap    = tick_i && (cnt_q == {CW{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (match_o)     cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
      if (cmp_we_i)    cmp_q <= cmp_wdata_i;  // live register, no shadow
    end
  end

  // sticky flags: set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_flag_o <= 1'b0;
      ovf_flag_o   <= 1'b0;
    end else begin
      if (match_o)          match_flag_o <= 1'b1;
      else if (match_clr_i) match_flag_o <= 1'b0;
      if (wrap)             ovf_flag_o   <= 1'b1;
      else if (ovf_clr_i)   ovf_flag_o   <= 1'b0;
    end
  end

  p_clear_on_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> (cnt_q == '0));
  p_hold_no_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  p_wrap_sets_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (ovf_flag_o && cnt_q == '0));
  p_match_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && match_clr_i) |=> match_flag_o);
  // R3: a count beyond the compare value can only go up or wrap, never clear early
  p_no_early_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_q > cmp_q && cnt_q != {CW{1'b1}}) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/ctc_wave.sv
module ctc_wave
  import ctc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_i,
  input  logic [1:0] mode_i,
  input  logic       oe_i,
  output logic       pin_o
);
  logic wave_q;
  logic toggle_en;

  assign toggle_en = (mode_i == MODE_TOGGLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   wave_q <= 1'b0;
    else if (match_i && toggle_en) wave_q <= ~wave_q;
  end

  assign pin_o = oe_i && toggle_en && wave_q;

  p_toggle_on_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && toggle_en) |=> (wave_q != $past(wave_q)));
  p_hold_other_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !toggle_en |=> $stable(wave_q));
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer
  import ctc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       clk_sel_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic [1:0]       out_mode_i,
  input  logic             pin_oe_i,
  input  logic             match_clr_i,
  input  logic             ovf_clr_i,
  output logic             wave_o,
  output logic             match_flag_o,
  output logic             ovf_flag_o
);
  logic tick, match;

  ctc_prescaler #(.DW(DIV_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (clk_sel_i),
    .tick_o(tick)
  );

  ctc_counter #(.CW(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .match_clr_i (match_clr_i),
    .ovf_clr_i   (ovf_clr_i),
    .match_o     (match),
    .match_flag_o(match_flag_o),
    .ovf_flag_o  (ovf_flag_o)
  );

  ctc_wave u_wave (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match),
    .mode_i (out_mode_i),
    .oe_i   (pin_oe_i),
    .pin_o  (wave_o)
  );

  p_pin_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_oe_i || out_mode_i != MODE_TOGGLE) |-> !wave_o);
  p_halt_no_tick_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_i == 3'(SEL_OFF) || clk_sel_i > 3'(SEL_D1024)) |-> !tick);
  p_match_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> match_flag_o);
endmodule

// File: tb/ctc_timer_tb.sv
module ctc_timer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  clk_sel = '0;
  logic        cmp_we = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic [1:0]  out_mode = '0;
  logic        pin_oe = 1'b0;
  logic        match_clr = 1'b0;
  logic        ovf_clr = 1'b0;
  logic        wave, mflag, oflag;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R8";

  // reference state
  int m_div = 0, m_cnt = 0, m_cmp = 0;
  bit m_wave = 0, m_mf = 0, m_of = 0;

  always #10 clk = ~clk;  // 50 MHz

  ctc_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_sel_i(clk_sel), .cmp_we_i(cmp_we),
    .cmp_wdata_i(cmp_wdata), .out_mode_i(out_mode), .pin_oe_i(pin_oe),
    .match_clr_i(match_clr), .ovf_clr_i(ovf_clr), .wave_o(wave),
    .match_flag_o(mflag), .ovf_flag_o(oflag)
  );

  function automatic int ratio(logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_div = 0; m_cnt = 0; m_cmp = 0; m_wave = 0; m_mf = 0; m_of = 0;
    end else begin
      int n;
      bit tk, mt, ov;
      n  = ratio(clk_sel);
      tk = (n != 0) && ((m_div % n) == n - 1);
      mt = tk && (m_cnt == m_cmp);
      ov = tk && (m_cnt == 65535);
      if (mt) m_cnt = 0;
      else if (tk) m_cnt = (m_cnt + 1) % 65536;
      if (mt) m_mf = 1; else if (match_clr) m_mf = 0;
      if (ov) m_of = 1; else if (ovf_clr) m_of = 0;
      if (mt && out_mode == 2'd1) m_wave = !m_wave;
      if (cmp_we) m_cmp = cmp_wdata;
      m_div = (m_div + 1) % 1024;
      cycles++;
    end
  end

  task automatic check(string t, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    check(tag, "wave_o", wave, (pin_oe && out_mode == 2'd1) ? m_wave : 0);
    check(tag, "match_flag_o", mflag, m_mf);
    check(tag, "ovf_flag_o", oflag, m_of);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(int v);
    @(negedge clk);
    cmp_we = 1'b1; cmp_wdata = 16'(v);
    @(negedge clk);
    cmp_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #2000000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R8: reset state
    tag = "R8";
    run(3);
    check("R8", "wave_o reset", wave, 0);
    check("R8", "match_flag_o reset", mflag, 0);
    check("R8", "ovf_flag_o reset", oflag, 0);
    @(negedge clk); rst_ni = 1'b1;

    // R9: compare 0 at full rate, pin toggles every clock
    tag = "R9";
    out_mode = 2'd1; pin_oe = 1'b1; clk_sel = 3'd1;
    run(3);
    begin
      logic w0;
      w0 = wave;
      @(negedge clk);
      check("R9", "half-rate toggle", wave, !w0);
    end
    run(10);

    // R6 and R7 set-beats-clear: clears asserted while matches fire every clock
    tag = "R6";
    match_clr = 1'b1; ovf_clr = 1'b1;
    run(8);
    check("R6", "flag held under clear", mflag, 1);
    clk_sel = 3'd0;
    run(2);
    check("R6", "flag cleared", mflag, 0);
    match_clr = 1'b0; ovf_clr = 1'b0;

    // R2 and R4: compare 5 at full rate
    tag = "R2";
    wr_cmp(5); clk_sel = 3'd1;
    run(40);

    // R4: mode 2 holds the waveform bit; R5: pin forced low
    tag = "R4";
    out_mode = 2'd2;
    run(30);
    out_mode = 2'd1;
    tag = "R5";
    pin_oe = 1'b0;
    run(30);
    check("R5", "pin low when disabled", wave, 0);
    pin_oe = 1'b1;
    out_mode = 2'd0;
    run(20);
    out_mode = 2'd1;

    // R1: every divide ratio, then the halt selects
    tag = "R1";
    wr_cmp(3);
    clk_sel = 3'd2; run(200);
    clk_sel = 3'd3; run(700);
    clk_sel = 3'd4; run(2100);
    wr_cmp(1);
    clk_sel = 3'd5; run(4200);
    clk_sel = 3'd0; run(100);
    clk_sel = 3'd6; run(100);
    clk_sel = 3'd7; run(100);

    // R3: lower compare below the running count, expect a full wrap
    tag = "R3";
    clk_sel = 3'd1;
    wr_cmp(1000);
    while (m_cnt < 500) @(negedge clk);
    wr_cmp(100);
    match_clr = 1'b1; @(negedge clk); match_clr = 1'b0;
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    run(60000);
    check("R3", "no match before wrap", mflag, 0);
    check("R7", "no overflow yet", oflag, 0);
    run(5200);
    check("R7", "overflow after wrap", oflag, 1);
    check("R3", "match after wrap", mflag, 1);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    @(negedge clk);
    check("R7", "overflow cleared", oflag, 0);
    run(50);

    finish_run();
  end
endmodule